// File: doc/BRIEF.md
# PHY Power State Controller

This block is the PHY-side power and operating-mode sequencer for a synchronous MAC-PHY link. It tracks six operating states (reset, sleep, standby, ready, transmit, receive), drives the PHY activity line back to the MAC, reports when the PHY is ready after a reset, qualifies clear-channel reporting and indicates when the PHY clock can be trusted. The MAC steers it with a reset line, the transmit and receive enables, and writes to a power-mode field.

Mode changes come from the levels of the two enables and from the activity line. A sleeping PHY is woken by raising both enables together. The PHY then enters standby and raises the activity line. The MAC closes the handshake by dropping both enables. Frame completion in transmit or receive is reported to the block as a single-cycle pulse. The reset-completion time and the clear-channel valid time are parameters counted in clock cycles. A parameter flag chooses whether the clock-valid indication also drops in sleep.

Top module: `phy_pwr_ctrl`

## Requirements
- R1: A high phy_reset_i at a clock edge puts the block in the reset state at that edge, whatever the current state. rst_ni low puts it there at once.
- R2: phy_active_o is high in the reset state. Once phy_reset_i has been low for RST_CYCLES+1 consecutive edges in reset, the block enters standby and phy_active_o falls.
- R3: rdy_o is 0 from the edge that samples phy_reset_i high, and after rst_ni. It becomes 1 at the edge that enters standby from reset and stays 1 until the next reset.
- R4: On a pm_wr_i pulse, pm_mode_i selects a mode: 0 is ready, 1 is standby, 2 is sleep, 3 does nothing. Standby accepts 0 and 2, and ready accepts 1. Any other write has no effect, including every write in sleep and a write of 2 in ready.
- R5: In sleep, both enables high move the block to standby at the next edge with phy_active_o high. A single enable in sleep has no effect.
- R6: After a wake, phy_active_o stays high and power-mode writes are ignored until an edge samples both enables low. At that edge phy_active_o falls.
- R7: In ready, tx_en_i alone enters transmit and rx_en_i alone enters receive. Both together enter standby, and this takes priority over a power-mode write. Dropping the active enable returns the block to ready.
- R8: phy_active_o rises on entry to transmit or receive and falls at the edge that samples frame_end_i high.
- R9: cca_report_o can be 1 only once cca_en_i has been high for CCA_VALID consecutive edges. It is 0 from the first edge that samples cca_en_i low.
- R10: cca_report_o is 0 in transmit, standby, sleep and reset, and is allowed in ready and receive.
- R11: clk_valid_o is 0 in reset. It is also 0 in sleep when GATE_CLK_IN_SLEEP is 1, the default. It is 1 in every other state.
- R12: state_o reports the state with the codes reset 0, sleep 1, standby 2, ready 3, transmit 4, receive 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PHY clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phy_reset_i | input | 1 | Synchronous PHY reset from the MAC |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| rx_en_i | input | 1 | Receive enable from the MAC |
| pm_wr_i | input | 1 | Power-mode field write strobe |
| pm_mode_i | input | 2 | Power-mode value written |
| cca_en_i | input | 1 | Clear-channel reporting enable bit |
| frame_end_i | input | 1 | Single-cycle end-of-frame pulse |
| phy_active_o | output | 1 | PHY activity line to the MAC |
| rdy_o | output | 1 | Ready-after-reset status bit |
| cca_report_o | output | 1 | Clear-channel report qualifier |
| clk_valid_o | output | 1 | PHY clock is stable |
| state_o | output | 3 | Current operating state code |

## Verification
The assertions assume that phy_reset_i, the enables, pm_wr_i and frame_end_i are synchronous to clk_i. They also assume frame_end_i is a single-cycle pulse given only while a frame is in flight. The stimulus changes every input one time unit after a rising edge and holds it through the next edge. It pulses pm_wr_i and frame_end_i for exactly one cycle and drops both enables before it asks for another mode change out of standby.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;
  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_SLEEP    = 3'd1,
    ST_STANDBY  = 3'd2,
    ST_READY    = 3'd3,
    ST_TRANSMIT = 3'd4,
    ST_RECEIVE  = 3'd5
  } phy_state_e;

  localparam logic [1:0] PM_READY   = 2'd0;
  localparam logic [1:0] PM_STANDBY = 2'd1;
  localparam logic [1:0] PM_SLEEP   = 2'd2;
endpackage

// File: rtl/phy_rst_seq.sv
module phy_rst_seq #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phy_reset_i,
  input  logic in_reset_i,
  output logic done_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] DONE_CNT = CW'(RST_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (phy_reset_i || !in_reset_i) cnt_q <= '0;
    else if (cnt_q != DONE_CNT)          cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = in_reset_i && (cnt_q == DONE_CNT);

  // R2
  early_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_reset_i |=> !done_o);
endmodule

// File: rtl/phy_mode_fsm.sv
module phy_mode_fsm
  import phy_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       phy_reset_i,
  input  logic       rst_done_i,
  input  logic       tx_en_i,
  input  logic       rx_en_i,
  input  logic       pm_wr_i,
  input  logic [1:0] pm_mode_i,
  input  logic       frame_end_i,
  output phy_state_e state_o,
  output logic       phy_active_o,
  output logic       rdy_o
);
  phy_state_e st_q, st_d;
  logic wake_hs_q, wake_hs_d;
  logic busy_q, busy_d;
  logic rdy_q, rdy_d;
  logic both_en, none_en, in_frame_d;

  assign both_en = tx_en_i && rx_en_i;
  assign none_en = !tx_en_i && !rx_en_i;

  always_comb begin
    st_d = st_q;
    if (phy_reset_i) st_d = ST_RESET;
    else begin
      unique case (st_q)
        ST_RESET:   if (rst_done_i) st_d = ST_STANDBY;
        ST_SLEEP:   if (both_en) st_d = ST_STANDBY;
        ST_STANDBY: begin
          if (!wake_hs_q && pm_wr_i) begin
            if (pm_mode_i == PM_READY)      st_d = ST_READY;
            else if (pm_mode_i == PM_SLEEP) st_d = ST_SLEEP;
          end
        end
        ST_READY: begin
          if (both_en)       st_d = ST_STANDBY;
          else if (tx_en_i)  st_d = ST_TRANSMIT;
          else if (rx_en_i)  st_d = ST_RECEIVE;
          else if (pm_wr_i && pm_mode_i == PM_STANDBY) st_d = ST_STANDBY;
        end
        ST_TRANSMIT: if (!tx_en_i) st_d = ST_READY;
        ST_RECEIVE:  if (!rx_en_i) st_d = ST_READY;
        default:     st_d = ST_RESET;
      endcase
    end
  end

  assign in_frame_d = (st_d == ST_TRANSMIT) || (st_d == ST_RECEIVE);

  always_comb begin
    wake_hs_d = wake_hs_q;
    if (phy_reset_i) wake_hs_d = 1'b0;
    else if (st_q == ST_SLEEP && both_en) wake_hs_d = 1'b1;
    else if (st_q == ST_STANDBY && none_en) wake_hs_d = 1'b0;

    busy_d = busy_q;
    if (phy_reset_i || !in_frame_d) busy_d = 1'b0;
    else if (st_d != st_q) busy_d = 1'b1;
    else if (frame_end_i) busy_d = 1'b0;

    rdy_d = rdy_q;
    if (phy_reset_i) rdy_d = 1'b0;
    else if (st_q == ST_RESET && rst_done_i) rdy_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_RESET;
      wake_hs_q <= 1'b0;
      busy_q    <= 1'b0;
      rdy_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      wake_hs_q <= wake_hs_d;
      busy_q    <= busy_d;
      rdy_q     <= rdy_d;
    end
  end

  assign state_o      = st_q;
  assign rdy_o        = rdy_q;
  assign phy_active_o = (st_q == ST_RESET) || wake_hs_q || busy_q;

  // R1
  reset_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_reset_i |=> (st_q == ST_RESET) && phy_active_o);
  // R2
  reset_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RESET && !rst_done_i) |=> st_q == ST_RESET);
  // R3
  rdy_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_q && !phy_reset_i) |=> rdy_q);
  // R5
  wake_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLEEP && both_en && !phy_reset_i) |=> (st_q == ST_STANDBY) && phy_active_o);
  // R6
  wake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_hs_q && st_q == ST_STANDBY && !phy_reset_i) |=> st_q == ST_STANDBY);
  // R7
  tx_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TRANSMIT && !tx_en_i && !phy_reset_i) |=> st_q == ST_READY);
endmodule

// File: rtl/phy_cca_gate.sv
module phy_cca_gate
  import phy_pwr_pkg::*;
#(
  parameter int CCA_VALID = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cca_en_i,
  input  phy_state_e state_i,
  output logic       report_o
);
  localparam int CW = $clog2(CCA_VALID + 1);
  localparam logic [CW-1:0] VALID_CNT = CW'(CCA_VALID);

  logic [CW-1:0] cnt_q;
  logic          state_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!cca_en_i)          cnt_q <= '0;
    else if (cnt_q != VALID_CNT) cnt_q <= cnt_q + 1'b1;
  end

  assign state_ok = (state_i == ST_READY) || (state_i == ST_RECEIVE);
  assign report_o = (cnt_q == VALID_CNT) && state_ok;

  // R9
  cca_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cca_en_i |=> !report_o);
endmodule

// File: rtl/phy_pwr_ctrl.sv
module phy_pwr_ctrl
  import phy_pwr_pkg::*;
#(
  parameter int RST_CYCLES        = 8,
  parameter int CCA_VALID         = 5,
  parameter bit GATE_CLK_IN_SLEEP = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       phy_reset_i,
  input  logic       tx_en_i,
  input  logic       rx_en_i,
  input  logic       pm_wr_i,
  input  logic [1:0] pm_mode_i,
  input  logic       cca_en_i,
  input  logic       frame_end_i,
  output logic       phy_active_o,
  output logic       rdy_o,
  output logic       cca_report_o,
  output logic       clk_valid_o,
  output logic [2:0] state_o
);
  phy_state_e st;
  logic       rst_done;

  phy_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phy_reset_i (phy_reset_i),
    .in_reset_i  (st == ST_RESET),
    .done_o      (rst_done)
  );

  phy_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phy_reset_i  (phy_reset_i),
    .rst_done_i   (rst_done),
    .tx_en_i      (tx_en_i),
    .rx_en_i      (rx_en_i),
    .pm_wr_i      (pm_wr_i),
    .pm_mode_i    (pm_mode_i),
    .frame_end_i  (frame_end_i),
    .state_o      (st),
    .phy_active_o (phy_active_o),
    .rdy_o        (rdy_o)
  );

  phy_cca_gate #(.CCA_VALID(CCA_VALID)) u_cca (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cca_en_i (cca_en_i),
    .state_i  (st),
    .report_o (cca_report_o)
  );

  generate
    if (GATE_CLK_IN_SLEEP) begin : g_gate_sleep
      assign clk_valid_o = (st != ST_RESET) && (st != ST_SLEEP);
    end else begin : g_no_gate
      assign clk_valid_o = (st != ST_RESET);
    end
  endgenerate

  assign state_o = st;

  // R10
  cca_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cca_report_o |-> (state_o == 3'd3 || state_o == 3'd5));
  // R3
  rdy_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_reset_i |=> !rdy_o);
endmodule

// File: tb/sim_phy_pwr_ctrl.sv
module sim_phy_pwr_ctrl;
  localparam int RST_N = 8;
  localparam int CCA_N = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic phy_reset_i = 1'b0, tx_en_i = 1'b0, rx_en_i = 1'b0;
  logic pm_wr_i = 1'b0, cca_en_i = 1'b0, frame_end_i = 1'b0;
  logic [1:0] pm_mode_i = 2'd0;
  logic phy_active_o, rdy_o, cca_report_o, clk_valid_o;
  logic [2:0] state_o;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  phy_pwr_ctrl #(.RST_CYCLES(RST_N), .CCA_VALID(CCA_N), .GATE_CLK_IN_SLEEP(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .phy_reset_i(phy_reset_i), .tx_en_i(tx_en_i),
    .rx_en_i(rx_en_i), .pm_wr_i(pm_wr_i), .pm_mode_i(pm_mode_i), .cca_en_i(cca_en_i),
    .frame_end_i(frame_end_i), .phy_active_o(phy_active_o), .rdy_o(rdy_o),
    .cca_report_o(cca_report_o), .clk_valid_o(clk_valid_o), .state_o(state_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pm_write(input logic [1:0] code);
    pm_mode_i = code; pm_wr_i = 1'b1;
    step(1);
    pm_wr_i = 1'b0;
  endtask

  task automatic t_reset_seq();
    chk("R12 reset code", state_o, 0);
    chk("R2 active in reset", phy_active_o, 1);
    chk("R3 rdy low in reset", rdy_o, 0);
    chk("R11 clk invalid in reset", clk_valid_o, 0);
    step(RST_N);
    chk("R2 still reset at RST_CYCLES", state_o, 0);
    step(1);
    chk("R2 standby reached", state_o, 2);
    chk("R2 active dropped", phy_active_o, 0);
    chk("R3 rdy set", rdy_o, 1);
    chk("R11 clk valid standby", clk_valid_o, 1);
  endtask

  task automatic t_pm_writes();
    pm_write(2'd0);
    chk("R4 standby to ready", state_o, 3);
    pm_write(2'd2);
    chk("R4 sleep write ignored in ready", state_o, 3);
    pm_write(2'd3);
    chk("R4 code 3 ignored", state_o, 3);
    pm_write(2'd1);
    chk("R4 ready to standby", state_o, 2);
    pm_write(2'd2);
    chk("R4 standby to sleep", state_o, 1);
    chk("R11 clk gated in sleep", clk_valid_o, 0);
    pm_write(2'd0);
    chk("R4 write ignored in sleep", state_o, 1);
    chk("R3 rdy kept", rdy_o, 1);
  endtask

  task automatic t_wake();
    tx_en_i = 1'b1;
    step(1);
    chk("R5 single enable ignored", state_o, 1);
    chk("R5 no active on single enable", phy_active_o, 0);
    rx_en_i = 1'b1;
    step(1);
    chk("R5 wake to standby", state_o, 2);
    chk("R5 active on wake", phy_active_o, 1);
    pm_write(2'd0);
    chk("R6 write ignored during handshake", state_o, 2);
    chk("R6 active held", phy_active_o, 1);
    tx_en_i = 1'b0; rx_en_i = 1'b0;
    step(1);
    chk("R6 handshake done", phy_active_o, 0);
    pm_write(2'd0);
    chk("R6 writes accepted after", state_o, 3);
  endtask

  task automatic t_txrx();
    tx_en_i = 1'b1;
    step(1);
    chk("R7 ready to transmit", state_o, 4);
    chk("R8 active in frame", phy_active_o, 1);
    step(2);
    chk("R8 active held", phy_active_o, 1);
    frame_end_i = 1'b1;
    step(1);
    frame_end_i = 1'b0;
    chk("R8 active drops at frame end", phy_active_o, 0);
    chk("R7 still transmit", state_o, 4);
    tx_en_i = 1'b0;
    step(1);
    chk("R7 back to ready", state_o, 3);
    rx_en_i = 1'b1;
    step(1);
    chk("R7 ready to receive", state_o, 5);
    chk("R8 active in rx", phy_active_o, 1);
    rx_en_i = 1'b0;
    step(1);
    chk("R7 rx back to ready", state_o, 3);
    chk("R8 active cleared on exit", phy_active_o, 0);
    tx_en_i = 1'b1; rx_en_i = 1'b1; pm_mode_i = 2'd2; pm_wr_i = 1'b1;
    step(1);
    pm_wr_i = 1'b0;
    chk("R7 both enables to standby", state_o, 2);
    tx_en_i = 1'b0; rx_en_i = 1'b0;
    step(1);
    pm_write(2'd0);
    chk("R4 back to ready", state_o, 3);
  endtask

  task automatic t_cca();
    cca_en_i = 1'b1;
    step(CCA_N - 1);
    chk("R9 not yet valid", cca_report_o, 0);
    step(1);
    chk("R9 valid after time", cca_report_o, 1);
    tx_en_i = 1'b1;
    step(1);
    chk("R10 suppressed in transmit", cca_report_o, 0);
    tx_en_i = 1'b0;
    step(1);
    chk("R10 allowed in ready", cca_report_o, 1);
    rx_en_i = 1'b1;
    step(1);
    chk("R10 allowed in receive", cca_report_o, 1);
    rx_en_i = 1'b0;
    step(1);
    pm_write(2'd1);
    chk("R10 suppressed in standby", cca_report_o, 0);
    pm_write(2'd0);
    chk("R10 ready again", cca_report_o, 1);
    cca_en_i = 1'b0;
    step(1);
    chk("R9 drops with enable", cca_report_o, 0);
    cca_en_i = 1'b1;
    step(1);
    chk("R9 restarts count", cca_report_o, 0);
    cca_en_i = 1'b0;
    step(1);
  endtask

  task automatic t_phy_reset();
    tx_en_i = 1'b1;
    step(1);
    chk("R7 transmit before reset", state_o, 4);
    phy_reset_i = 1'b1;
    step(1);
    chk("R1 forced to reset", state_o, 0);
    chk("R2 active in reset", phy_active_o, 1);
    chk("R3 rdy cleared", rdy_o, 0);
    tx_en_i = 1'b0;
    step(3);
    chk("R1 held in reset", state_o, 0);
    phy_reset_i = 1'b0;
    step(RST_N);
    chk("R2 still reset", state_o, 0);
    step(1);
    chk("R2 standby again", state_o, 2);
    chk("R3 rdy again", rdy_o, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    t_reset_seq();
    t_pm_writes();
    t_wake();
    t_txrx();
    t_cca();
    t_phy_reset();
    finish_run();
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule